// File: doc/BRIEF.md
# Edge-Sensed Pin Interrupt Controller

This block sits inside a port expander and watches a set of synchronised input pins for programmed edges. For each pin a two-bit sense code picks rising edges, falling edges, both, or none. A pin that sees a qualifying edge latches a bit in a per-pin pending register. An active-low interrupt line goes to the host whenever a pending bit is set and that pin is not masked.

Software reaches the block through a plain synchronous register port with address, write data, a write strobe, a read strobe and combinational read data. The host services an interrupt by reading the pending register and writing ones to the bits it has handled. A control bit selects whether a read of the pin-level register also clears every pending bit.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Pin p uses sense bits [2p+1:2p] of the SENSE register (address 3). Code 1 detects rising edges, code 2 detects falling edges, code 3 detects both, and code 0 detects none. An edge is a change between the previous and the current clock sample of the pin.
- R2: A qualifying edge sets bit p of the pending register (address 4) at the clock edge that follows the pin change. The bit then stays set until something clears it.
- R3: Writing the pending register clears each bit written as 1. Bits written as 0 are unchanged.
- R4: If an edge and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R5: irq_n is low exactly while some pending bit is set whose MASK bit (address 2) is 0. A MASK bit of 1 blocks its pin from the interrupt.
- R6: After reset, MASK and DIR (address 1) read as all ones, SENSE, the pending register and CTRL (address 5) read as zero, and irq_n is high.
- R7: Only pins whose DIR bit is 1 (input) can set pending bits. A pin whose DIR bit is 0 (output) sets nothing.
- R8: While CTRL bit 0 is 0, a read strobe at the DATA address (0) clears all pending bits one cycle after the strobe.
- R9: While CTRL bit 0 is 1, a read strobe at DATA leaves the pending bits unchanged. Only a write-one clears them.
- R10: Reading DATA returns the current pin levels in bits [NUM_PINS-1:0], with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Synchronised pin levels |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 2*NUM_PINS | Write data |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe, used by the auto-clear |
| reg_rdata_o | output | 2*NUM_PINS | Read data for the addressed register |
| irq_n_o | output | 1 | Active-low interrupt to the host |

## Verification
The bench builds the block with its default of 16 pins, so the bus is 32 bits wide and the sense field spans the whole word. That lets the vector table place sense codes near the top of the word, at pins 10 and 15, as well as at pin 0. A different pin width would not reach those field positions. Directed tests then cover the same-cycle set-and-clear race and the two-cycle timing of the auto-clear. They also cover auto-clear turned off, output pins that stay silent, and masking.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    ADR_DATA   = 3'd0,
    ADR_DIR    = 3'd1,
    ADR_MASK   = 3'd2,
    ADR_SENSE  = 3'd3,
    ADR_SOURCE = 3'd4,
    ADR_CTRL   = 3'd5
  } reg_addr_e;

  localparam int unsigned SENSE_BITS = 2;
  localparam logic [1:0] SENSE_RISE = 2'b01;
  localparam logic [1:0] SENSE_FALL = 2'b10;
endpackage

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [NUM_PINS-1:0]   dir_i,
  input  logic [2*NUM_PINS-1:0] sense_i,
  output logic [NUM_PINS-1:0]   evt_o
);
  import gpio_irq_pkg::*;

  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_i;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SENSE_BITS-1:0] code;
    logic rise, fall;
    assign code = sense_i[SENSE_BITS*p +: SENSE_BITS];
    assign rise = pin_i[p] & ~prev_q[p] & code[0];
    assign fall = ~pin_i[p] & prev_q[p] & code[1];
    assign evt_o[p] = dir_i[p] & (rise | fall);
  end
endmodule

// File: rtl/gpio_irq_source.sv
module gpio_irq_source #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic [NUM_PINS-1:0] clr_i,
  input  logic                flush_i,
  output logic [NUM_PINS-1:0] src_o
);
  logic [NUM_PINS-1:0] src_q, src_d;

  always_comb begin
    src_d = src_q;
    if (flush_i) src_d = '0;
    src_d = (src_d & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  assign src_o = src_q;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0 && !flush_i) |=> $stable(src_q));

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((src_q & $past(clr_i & ~set_i)) == '0));

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((src_q & $past(set_i)) == $past(set_i)));

  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && set_i == '0) |=> (src_q == '0));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs #(
  parameter int unsigned NUM_PINS = 16,
  localparam int unsigned DW = 2*NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] src_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [DW-1:0]       sense_o,
  output logic [NUM_PINS-1:0] clr_o,
  output logic                flush_o,
  output logic [DW-1:0]       rdata_o
);
  import gpio_irq_pkg::*;

  reg_addr_e adr;
  logic [NUM_PINS-1:0] dir_q, dir_d, mask_q, mask_d;
  logic [DW-1:0]       sense_q, sense_d;
  logic                keep_q, keep_d, flush_q, flush_d;
  logic                dir_en, mask_en, sense_en, ctrl_en;

  assign adr      = reg_addr_e'(addr_i);
  assign dir_en   = wr_i && adr == ADR_DIR;
  assign mask_en  = wr_i && adr == ADR_MASK;
  assign sense_en = wr_i && adr == ADR_SENSE;
  assign ctrl_en  = wr_i && adr == ADR_CTRL;

  always_comb begin
    dir_d   = dir_en   ? wdata_i[NUM_PINS-1:0] : dir_q;
    mask_d  = mask_en  ? wdata_i[NUM_PINS-1:0] : mask_q;
    sense_d = sense_en ? wdata_i : sense_q;
    keep_d  = ctrl_en  ? wdata_i[0] : keep_q;
    flush_d = rd_i && adr == ADR_DATA && !keep_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      mask_q  <= '1;
      sense_q <= '0;
      keep_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      dir_q   <= dir_d;
      mask_q  <= mask_d;
      sense_q <= sense_d;
      keep_q  <= keep_d;
      flush_q <= flush_d;
    end
  end

  assign clr_o   = (wr_i && adr == ADR_SOURCE) ? wdata_i[NUM_PINS-1:0] : '0;
  assign flush_o = flush_q;
  assign dir_o   = dir_q;
  assign mask_o  = mask_q;
  assign sense_o = sense_q;

  always_comb begin
    rdata_o = '0;
    unique case (adr)
      ADR_DATA:   rdata_o[NUM_PINS-1:0] = pins_i;
      ADR_DIR:    rdata_o[NUM_PINS-1:0] = dir_q;
      ADR_MASK:   rdata_o[NUM_PINS-1:0] = mask_q;
      ADR_SENSE:  rdata_o = sense_q;
      ADR_SOURCE: rdata_o[NUM_PINS-1:0] = src_i;
      ADR_CTRL:   rdata_o[0] = keep_q;
      default:    rdata_o = '0;
    endcase
  end

  a_r9_no_flush_when_kept: assert property (@(posedge clk) disable iff (!rst_n)
    keep_q |=> !flush_q);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int unsigned NUM_PINS = 16,
  localparam int unsigned DW = 2*NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [DW-1:0]       reg_wdata_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  output logic [DW-1:0]       reg_rdata_o,
  output logic                irq_n_o
);
  logic [NUM_PINS-1:0] dir, mask, clr, evt, src;
  logic [DW-1:0]       sense;
  logic                flush;

  gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .pins_i(pin_i), .src_i(src),
    .dir_o(dir), .mask_o(mask), .sense_o(sense), .clr_o(clr),
    .flush_o(flush), .rdata_o(reg_rdata_o));

  gpio_irq_edge #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .dir_i(dir),
    .sense_i(sense), .evt_o(evt));

  gpio_irq_source #(.NUM_PINS(NUM_PINS)) u_src (
    .clk(clk), .rst_n(rst_n), .set_i(evt), .clr_i(clr),
    .flush_i(flush), .src_o(src));

  assign irq_n_o = ~|(src & ~mask);

  a_r7_outputs_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~dir) == '0);

  a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((src & $past(evt)) != '0));
endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int N = 16;
  localparam int DW = 2*N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] rdata;
  logic irq_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_rdata_o(rdata), .irq_n_o(irq_n));

  // {sense code[1:0], level before, level after, expected pending}
  localparam logic [4:0] VEC [8] = '{
    5'b01_0_1_1, 5'b01_1_0_0, 5'b10_1_0_1, 5'b10_0_1_0,
    5'b11_0_1_1, 5'b11_1_0_1, 5'b00_0_1_0, 5'b00_1_0_0};

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  function automatic logic [DW-1:0] peek(input logic [2:0] a);
    addr = a;
    return rdata;
  endfunction

  task automatic rd_reg(input logic [2:0] a, output logic [DW-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    #(8*100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    rd_reg(3'd2, v); chk("R6 mask", v, 32'h0000_ffff);
    rd_reg(3'd1, v); chk("R6 dir", v, 32'h0000_ffff);
    rd_reg(3'd3, v); chk("R6 sense", v, '0);
    rd_reg(3'd4, v); chk("R6 pending", v, '0);
    rd_reg(3'd5, v); chk("R6 ctrl", v, '0);
    chk("R6 irq_n", {31'd0, irq_n}, 32'd1);

    // R1 / R2 sense code vectors
    for (int i = 0; i < 8; i++) begin
      int p;
      p = (i * 5) % N;
      wr_reg(3'd3, {30'd0, VEC[i][4:3]} << (2*p));
      @(negedge clk); pins = {{(N-1){1'b0}}, VEC[i][2]} << p;
      repeat (2) @(negedge clk);
      wr_reg(3'd4, '1);
      pins = {{(N-1){1'b0}}, VEC[i][1]} << p;
      @(negedge clk);
      rd_reg(3'd4, v);
      chk("R1 R2 edge vector", v, {31'd0, VEC[i][0]} << p);
      @(negedge clk);
      rd_reg(3'd4, v);
      chk("R2 stays set", v, {31'd0, VEC[i][0]} << p);
    end
    pins = '0;
    wr_reg(3'd4, '1);

    // R10 data read
    @(negedge clk); pins = 16'ha5c3;
    rd_reg(3'd0, v); chk("R10 data read", v, 32'h0000_a5c3);
    pins = '0;
    repeat (2) @(negedge clk);

    // pin0 both edges; make pending
    wr_reg(3'd3, 32'h3);
    wr_reg(3'd4, '1);
    @(negedge clk); pins[0] = 1'b1;
    @(negedge clk);
    // R5 masked
    chk("R5 masked irq_n high", {31'd0, irq_n}, 32'd1);
    wr_reg(3'd2, 32'h0000_fffe);
    chk("R5 unmasked irq_n low", {31'd0, irq_n}, 32'd0);
    // R3 write zero leaves
    wr_reg(3'd4, '0);
    rd_reg(3'd4, v); chk("R3 write zero keeps", v, 32'h1);
    wr_reg(3'd4, 32'h1);
    rd_reg(3'd4, v); chk("R3 write one clears", v, 32'h0);
    chk("R5 irq_n high after clear", {31'd0, irq_n}, 32'd1);

    // R4 set wins over same-cycle clear
    @(negedge clk); pins[0] = 1'b0; addr = 3'd4; wdata = 32'h1; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rd_reg(3'd4, v); chk("R4 set wins", v, 32'h1);

    // R8 auto-clear timing
    @(negedge clk); addr = 3'd0; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    rd_reg(3'd4, v); chk("R8 not yet cleared", v, 32'h1);
    @(negedge clk);
    rd_reg(3'd4, v); chk("R8 cleared", v, 32'h0);

    // R9 auto-clear off
    wr_reg(3'd5, 32'h1);
    @(negedge clk); pins[0] = 1'b1;
    @(negedge clk); addr = 3'd0; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    repeat (2) @(negedge clk);
    rd_reg(3'd4, v); chk("R9 read keeps pending", v, 32'h1);
    wr_reg(3'd4, 32'h1);
    wr_reg(3'd5, 32'h0);

    // R7 output pin sets nothing, input neighbour does
    wr_reg(3'd1, 32'h0000_fffe);
    wr_reg(3'd3, 32'hf);
    @(negedge clk); pins[0] = 1'b0; pins[1] = 1'b1;
    @(negedge clk);
    rd_reg(3'd4, v); chk("R7 output pin ignored", v, 32'h2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule